// File: doc/BRIEF.md
# Inbound Address Translation Window Decoder

This block sits at the target side of a bus bridge and decides, for each incoming request address, whether one of several programmable inbound windows claims it. A claimed request gets a translated internal-bus address: the part of the address below the window size is kept and the window's translation value supplies the upper bits. Software programs each window's base, mask (limit) and translation value through a simple write/read register port. A control register holds a memory-space enable that, when clear, stops every claim.

Windows 0, 2 and 3 translate. Window 1 only reserves address space and never claims a request. When several translating windows match the same address, the lowest-numbered one wins. The first 4 KB of window 0 belong to a messaging unit, and requests that land there are flagged. A claimed request whose burst order is not linear-incrementing is flagged so that the bus side disconnects after the first data phase. All results appear on registered outputs one clock after the request strobe.

Top module: `inbound_window_decoder`

## Requirements
- R1: A translating window w matches when (req_addr & limit_w) == base_w, comparing all 32 bits. A request is claimed (resp_claim=1) only if some translating window matches.
- R2: For a claimed request, resp_addr = (req_addr & ~limit_w) | xlate_w of the winning window w.
- R3: Window 1 never claims a request, even when (req_addr & limit_1) == base_1. If no other window matches, resp_claim=0.
- R4: When more than one translating window matches, resp_win reports the lowest-numbered one and resp_addr uses its registers.
- R5: resp_mu=1 exactly when the request is claimed by window 0 and (req_addr & ~limit_0) is below 4096; otherwise 0.
- R6: resp_disc=1 when a claimed request has req_burst other than 2'b00 (2'b00 = linear incrementing, 2'b01 = wrap, 2'b10/2'b11 = other orders); 0 for linear bursts and for unclaimed requests.
- R7: The control register (select 4'h3, bit 0 = memory-space enable) resets to 0; while it is 0 no request is claimed.
- R8: resp_valid and all result outputs are registered: they reflect the request strobed on the previous clock, using register contents from before any write in that same cycle. Without a request, or for an unclaimed one, resp_claim, resp_win, resp_addr, resp_mu and resp_disc are 0.
- R9: Register select is {window[1:0], field[1:0]} with field 0 = base, 1 = limit, 2 = translation value, 3 = control (window 0 only). cfg_rd_data returns the register chosen by cfg_rd_sel one clock later. After reset base and limit are 0, the window 0 translation value is 32'hFF00_0000 and those of windows 2 and 3 are 0.
- R10: Bits 11:0 of every translation value read as 0 and ignore writes. The window 1 translation value and field 3 of windows 1 to 3 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 4 | Register select for writes |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_sel | input | 4 | Register select for reads |
| cfg_rd_data | output | 32 | Read data, one clock after the select |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_burst | input | 2 | Burst order code |
| resp_valid | output | 1 | Result of a request is present |
| resp_claim | output | 1 | Request claimed by a translating window |
| resp_win | output | 2 | Index of the claiming window |
| resp_addr | output | 32 | Translated internal-bus address |
| resp_mu | output | 1 | Request falls in the messaging-unit region |
| resp_disc | output | 1 | Disconnect after the first data phase |

## Verification
The hardest case to reach is an address that matches several windows at once, including the allocation-only window, so that priority and the window 1 exclusion are both exercised. The stimulus programs overlapping windows on purpose: window 3 lies inside window 2, and window 1 shares a region with nothing but itself. It then moves window 2 away to let window 3 win the same address. The messaging-unit boundary is hit with the last byte below 4 KB and the first byte above it. Writes issued in the same cycle as a request check that the decode uses the old register values.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

  // register field codes within one window's select group
  localparam logic [1:0] FLD_BASE  = 2'd0;
  localparam logic [1:0] FLD_LIMIT = 2'd1;
  localparam logic [1:0] FLD_XLATE = 2'd2;
  localparam logic [1:0] FLD_CTRL  = 2'd3;

  // burst order codes
  typedef enum logic [1:0] {
    BURST_LINEAR = 2'b00,
    BURST_WRAP   = 2'b01,
    BURST_OTHER2 = 2'b10,
    BURST_OTHER3 = 2'b11
  } burst_e;

endpackage

// File: rtl/iwd_regfile.sv
module iwd_regfile #(
  parameter int          ADDR_W    = 32,
  parameter int          NUM_WIN   = 4,
  parameter int          PAGE_BITS = 12,
  parameter int          ALLOC_WIN = 1,
  parameter logic [31:0] XLAT0_RST = 32'hFF00_0000,
  localparam int         WIN_W     = $clog2(NUM_WIN),
  localparam int         SEL_W     = WIN_W + 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [ADDR_W-1:0]               wr_data,
  input  logic [SEL_W-1:0]                rd_sel,
  output logic [ADDR_W-1:0]               rd_data,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_q,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  limit_q,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  xlate_q,
  output logic                            mem_en
);
  import iwd_pkg::*;

  logic [WIN_W-1:0] wr_win;
  logic [1:0]       wr_fld;
  logic [WIN_W-1:0] rd_win;
  logic [1:0]       rd_fld;
  logic [ADDR_W-1:0] rd_next;

  assign wr_win = wr_sel[SEL_W-1:2];
  assign wr_fld = wr_sel[1:0];
  assign rd_win = rd_sel[SEL_W-1:2];
  assign rd_fld = rd_sel[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit_sel;
    assign hit_sel = wr_en && (wr_win == WIN_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[w]  <= '0;
        limit_q[w] <= '0;
      end else if (hit_sel) begin
        if (wr_fld == FLD_BASE)  base_q[w]  <= wr_data;
        if (wr_fld == FLD_LIMIT) limit_q[w] <= wr_data;
      end
    end

    if (w == ALLOC_WIN) begin : g_noxl
      assign xlate_q[w] = '0;
    end else begin : g_xl
      localparam logic [ADDR_W-1:0] XRST = (w == 0) ? ADDR_W'(XLAT0_RST) : '0;
      logic [ADDR_W-1:PAGE_BITS] xl_hi;
      always_ff @(posedge clk) begin
        if (rst) begin
          xl_hi <= XRST[ADDR_W-1:PAGE_BITS];
        end else if (hit_sel && (wr_fld == FLD_XLATE)) begin
          xl_hi <= wr_data[ADDR_W-1:PAGE_BITS];
        end
      end
      assign xlate_q[w] = {xl_hi, {PAGE_BITS{1'b0}}};
    end
  end

  // control register lives in field 3 of window 0
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en <= 1'b0;
    end else if (wr_en && (wr_win == '0) && (wr_fld == FLD_CTRL)) begin
      mem_en <= wr_data[0];
    end
  end

  always_comb begin
    unique case (rd_fld)
      FLD_BASE:  rd_next = base_q[rd_win];
      FLD_LIMIT: rd_next = limit_q[rd_win];
      FLD_XLATE: rd_next = xlate_q[rd_win];
      default:   rd_next = (rd_win == '0) ? {{(ADDR_W-1){1'b0}}, mem_en} : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/iwd_window_match.sv
module iwd_window_match #(
  parameter int  ADDR_W    = 32,
  parameter int  NUM_WIN   = 4,
  parameter int  MU_BYTES  = 4096,
  parameter int  ALLOC_WIN = 1,
  parameter int  MU_WIN    = 0,
  localparam int MU_BITS   = $clog2(MU_BYTES)
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  base_q,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  limit_q,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xlate_q,
  output logic [NUM_WIN-1:0]              hit,
  output logic [NUM_WIN-1:0]              mu,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  xaddr
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [ADDR_W-1:0] offset;
    logic              in_win;

    assign offset   = addr & ~limit_q[w];
    assign in_win   = ((addr & limit_q[w]) == base_q[w]);
    assign xaddr[w] = offset | xlate_q[w];

    if (w == ALLOC_WIN) begin : g_alloc
      assign hit[w] = 1'b0;
      assign mu[w]  = 1'b0;
    end else if (w == MU_WIN) begin : g_mu
      assign hit[w] = in_win;
      assign mu[w]  = (offset[ADDR_W-1:MU_BITS] == '0);
    end else begin : g_plain
      assign hit[w] = in_win;
      assign mu[w]  = 1'b0;
    end
  end

endmodule

// File: rtl/iwd_select.sv
module iwd_select #(
  parameter int  ADDR_W  = 32,
  parameter int  NUM_WIN = 4,
  localparam int WIN_W   = $clog2(NUM_WIN)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic [1:0]                      req_burst,
  input  logic                            mem_en,
  input  logic [NUM_WIN-1:0]              hit,
  input  logic [NUM_WIN-1:0]              mu,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xaddr,
  output logic                            resp_valid,
  output logic                            resp_claim,
  output logic [WIN_W-1:0]                resp_win,
  output logic [ADDR_W-1:0]               resp_addr,
  output logic                            resp_mu,
  output logic                            resp_disc
);
  import iwd_pkg::*;

  logic             any_hit;
  logic [WIN_W-1:0] pick;
  logic             take;

  // scan from the top so that the lowest matching index is left last
  always_comb begin
    pick = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) pick = WIN_W'(w);
    end
  end

  assign any_hit = |hit;
  assign take    = req_valid && mem_en && any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_claim <= 1'b0;
      resp_win   <= '0;
      resp_addr  <= '0;
      resp_mu    <= 1'b0;
      resp_disc  <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_claim <= take;
      resp_win   <= take ? pick : '0;
      resp_addr  <= take ? xaddr[pick] : '0;
      resp_mu    <= take && mu[pick];
      resp_disc  <= take && (burst_e'(req_burst) != BURST_LINEAR);
    end
  end

endmodule

// File: rtl/inbound_window_decoder.sv
module inbound_window_decoder #(
  parameter int          ADDR_W    = 32,
  parameter int          NUM_WIN   = 4,
  parameter int          PAGE_BITS = 12,
  parameter int          MU_BYTES  = 4096,
  parameter int          ALLOC_WIN = 1,
  parameter int          MU_WIN    = 0,
  parameter logic [31:0] XLAT0_RST = 32'hFF00_0000,
  localparam int         WIN_W     = $clog2(NUM_WIN),
  localparam int         SEL_W     = WIN_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic [SEL_W-1:0]  cfg_rd_sel,
  output logic [ADDR_W-1:0] cfg_rd_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_burst,
  output logic              resp_valid,
  output logic              resp_claim,
  output logic [WIN_W-1:0]  resp_win,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              resp_mu,
  output logic              resp_disc
);

  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] limit_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] xlate_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr;
  logic [NUM_WIN-1:0]             hit;
  logic [NUM_WIN-1:0]             mu;
  logic                           mem_en;

  iwd_regfile #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .PAGE_BITS(PAGE_BITS),
    .ALLOC_WIN(ALLOC_WIN), .XLAT0_RST(XLAT0_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data),
    .base_q(base_q), .limit_q(limit_q), .xlate_q(xlate_q),
    .mem_en(mem_en)
  );

  iwd_window_match #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .MU_BYTES(MU_BYTES),
    .ALLOC_WIN(ALLOC_WIN), .MU_WIN(MU_WIN)
  ) u_match (
    .addr(req_addr), .base_q(base_q), .limit_q(limit_q), .xlate_q(xlate_q),
    .hit(hit), .mu(mu), .xaddr(xaddr)
  );

  iwd_select #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)
  ) u_sel (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_burst(req_burst), .mem_en(mem_en),
    .hit(hit), .mu(mu), .xaddr(xaddr),
    .resp_valid(resp_valid), .resp_claim(resp_claim), .resp_win(resp_win),
    .resp_addr(resp_addr), .resp_mu(resp_mu), .resp_disc(resp_disc)
  );

endmodule

// File: rtl/iwd_checker.sv
module iwd_checker #(
  parameter int  ADDR_W    = 32,
  parameter int  NUM_WIN   = 4,
  parameter int  PAGE_BITS = 12,
  parameter int  ALLOC_WIN = 1,
  parameter int  MU_WIN    = 0,
  localparam int WIN_W     = $clog2(NUM_WIN),
  localparam int SEL_W     = WIN_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  cfg_rd_sel,
  input logic [ADDR_W-1:0] cfg_rd_data,
  input logic              req_valid,
  input logic              mem_en,
  input logic              resp_valid,
  input logic              resp_claim,
  input logic [WIN_W-1:0]  resp_win,
  input logic              resp_mu,
  input logic              resp_disc
);

  // R3: the allocation-only window never shows up as the claimer
  assert_alloc_never_claims_R3: assert property (@(posedge clk) disable iff (rst)
    resp_claim |-> (resp_win != WIN_W'(ALLOC_WIN)));

  // R7: with memory space disabled a request is not claimed
  assert_disabled_no_claim_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mem_en) |=> !resp_claim);

  // R8: a claim only follows a strobed request
  assert_claim_needs_request_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !resp_claim));

  // R6: disconnect only accompanies a claim
  assert_disc_only_claimed_R6: assert property (@(posedge clk) disable iff (rst)
    resp_disc |-> resp_claim);

  // R5: messaging-unit flag only on a window 0 claim
  assert_mu_only_window0_R5: assert property (@(posedge clk) disable iff (rst)
    resp_mu |-> (resp_claim && resp_win == WIN_W'(MU_WIN)));

  // R10: translation value low bits always read as zero
  assert_xlate_low_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_rd_sel[1:0]) == 2'd2) |-> (cfg_rd_data[PAGE_BITS-1:0] == '0));

endmodule

bind inbound_window_decoder iwd_checker #(
  .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .PAGE_BITS(PAGE_BITS),
  .ALLOC_WIN(ALLOC_WIN), .MU_WIN(MU_WIN)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
  .req_valid(req_valid), .mem_en(mem_en), .resp_valid(resp_valid),
  .resp_claim(resp_claim), .resp_win(resp_win), .resp_mu(resp_mu),
  .resp_disc(resp_disc)
);

// File: tb/inbound_window_decoder_tb.sv
module inbound_window_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [3:0]  cfg_rd_sel = '0;
  logic [31:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_burst = '0;
  logic        resp_valid, resp_claim, resp_mu, resp_disc;
  logic [1:0]  resp_win;
  logic [31:0] resp_addr;

  always #2.5 clk = ~clk;

  inbound_window_decoder u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_burst(req_burst),
    .resp_valid(resp_valid), .resp_claim(resp_claim), .resp_win(resp_win),
    .resp_addr(resp_addr), .resp_mu(resp_mu), .resp_disc(resp_disc)
  );

  int total = 0;
  int bad   = 0;

  // behavioural model state
  logic [31:0] m_base [4];
  logic [31:0] m_lim  [4];
  logic [31:0] m_xl   [4];
  logic        m_men;

  // expected outputs for the next sample
  logic        e_valid, e_claim, e_mu, e_disc;
  logic [1:0]  e_win;
  logic [31:0] e_addr, e_rd;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_read(input logic [3:0] sel);
    int w = int'(sel[3:2]);
    case (sel[1:0])
      2'd0: return m_base[w];
      2'd1: return m_lim[w];
      2'd2: return (w == 1) ? 32'h0 : m_xl[w];
      default: return (w == 0) ? {31'b0, m_men} : 32'h0;
    endcase
  endfunction

  task automatic step(input bit wr, input logic [3:0] wsel, input logic [31:0] wd,
                      input logic [3:0] rsel, input bit rq, input logic [31:0] ra,
                      input logic [1:0] rb);
    @(negedge clk);
    chk("R8", "resp_valid", {31'b0, resp_valid}, {31'b0, e_valid});
    chk("R1 R3 R7", "resp_claim", {31'b0, resp_claim}, {31'b0, e_claim});
    chk("R4", "resp_win", {30'b0, resp_win}, {30'b0, e_win});
    chk("R2", "resp_addr", resp_addr, e_addr);
    chk("R5", "resp_mu", {31'b0, resp_mu}, {31'b0, e_mu});
    chk("R6", "resp_disc", {31'b0, resp_disc}, {31'b0, e_disc});
    chk("R9 R10", "cfg_rd_data", cfg_rd_data, e_rd);
    // expectation from pre-write state
    e_valid = rq; e_claim = 0; e_win = 0; e_addr = 0; e_mu = 0; e_disc = 0;
    if (rq && m_men) begin
      for (int w = 3; w >= 0; w--) begin
        if (w != 1 && ((ra & m_lim[w]) == m_base[w])) begin
          e_claim = 1; e_win = 2'(w);
          e_addr = (ra & ~m_lim[w]) | m_xl[w];
        end
      end
      if (e_claim) begin
        e_mu   = (e_win == 0) && (((ra & ~m_lim[0]) >> 12) == 0);
        e_disc = (rb != 2'b00);
      end
    end
    e_rd = mdl_read(rsel);
    if (wr) begin
      int w = int'(wsel[3:2]);
      case (wsel[1:0])
        2'd0: m_base[w] = wd;
        2'd1: m_lim[w] = wd;
        2'd2: if (w != 1) m_xl[w] = wd & 32'hFFFF_F000;
        default: if (w == 0) m_men = wd[0];
      endcase
    end
    cfg_wr_en = wr; cfg_wr_sel = wsel; cfg_wr_data = wd;
    cfg_rd_sel = rsel; req_valid = rq; req_addr = ra; req_burst = rb;
  endtask

  task automatic wreg(input logic [3:0] sel, input logic [31:0] d);
    step(1, sel, d, sel, 0, 0, 0);
  endtask

  task automatic rreg(input logic [3:0] sel);
    step(0, 0, 0, sel, 0, 0, 0);
  endtask

  task automatic req(input logic [31:0] a, input logic [1:0] b);
    step(0, 0, 0, 4'h2, 1, a, b);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 4; w++) begin
      m_base[w] = 0; m_lim[w] = 0; m_xl[w] = 0;
    end
    m_xl[0] = 32'hFF00_0000; m_men = 0;
    e_valid = 0; e_claim = 0; e_win = 0; e_addr = 0; e_mu = 0; e_disc = 0; e_rd = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9: reset values of every register, R10 unused fields read zero
    for (int s = 0; s < 16; s++) rreg(4'(s));

    // R7: all windows match at reset (limit 0), but memory space is off
    req(32'h1234_5678, 2'b00);
    req(32'h8000_0000, 2'b01);

    // programming; R10: low bits dropped, window 1 xlate and spare fields ignored
    wreg(4'h0, 32'h8000_0000); wreg(4'h1, 32'hFFF0_0000); wreg(4'h2, 32'h1234_5ABC);
    wreg(4'h4, 32'h9000_0000); wreg(4'h5, 32'hFFFF_0000); wreg(4'h6, 32'hDEAD_BEEF);
    wreg(4'h7, 32'hFFFF_FFFF);
    wreg(4'h8, 32'hA000_0000); wreg(4'h9, 32'hF000_0000); wreg(4'hA, 32'h0400_0FFF);
    wreg(4'hB, 32'h0000_0001);
    wreg(4'hC, 32'hA010_0000); wreg(4'hD, 32'hFFF0_0000); wreg(4'hE, 32'h5000_0000);
    for (int s = 0; s < 16; s++) rreg(4'(s));
    wreg(4'h3, 32'h1);   // R7 enable

    // R5 boundary, R2 translation, R6 burst codes
    req(32'h8000_0010, 2'b00);
    req(32'h8000_0FFF, 2'b01);
    req(32'h8000_1000, 2'b00);
    req(32'h800F_FFFC, 2'b10);
    // R3: window 1 region alone is not claimed
    req(32'h9000_0040, 2'b00);
    req(32'h9000_FFFF, 2'b11);
    // R4: overlap of windows 2 and 3, window 2 wins
    req(32'hA010_0020, 2'b00);
    req(32'hA010_0020, 2'b11);
    req(32'hAFFF_FFF0, 2'b01);
    // R1: misses
    req(32'hB000_0000, 2'b00);
    req(32'h7FFF_FFFF, 2'b00);
    // R8: write in the same cycle as a request uses the old value
    step(1, 4'h8, 32'hC000_0000, 4'h8, 1, 32'hA010_0040, 2'b00);
    req(32'hA010_0040, 2'b00);  // now window 3 (R4)
    req(32'hA020_0040, 2'b00);  // now a miss
    // window 0 overlapping window 3 base region: lowest wins
    wreg(4'h0, 32'hA000_0000); wreg(4'h1, 32'hF000_0000);
    req(32'hA010_0000, 2'b00);
    req(32'hA000_0800, 2'b01);
    wreg(4'h0, 32'h8000_0000); wreg(4'h1, 32'hFFF0_0000);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] a;
      case (r[31:29])
        3'd0: a = 32'h8000_0000 | {12'b0, r[19:0]};
        3'd1: a = 32'h8000_0000 | {20'b0, r[11:0]};
        3'd2: a = 32'h9000_0000 | {16'b0, r[15:0]};
        3'd3: a = 32'hA010_0000 | {12'b0, r[19:0]};
        3'd4: a = 32'hC000_0000 | {4'b0, r[27:0]};
        default: a = $urandom;
      endcase
      if (r[5]) wreg(4'h3, {31'b0, ~r[6] | r[7]});
      step(0, 0, 0, 4'(r[11:8]), r[4] | r[3], a, r[1:0]);
    end

    // R7: disable and confirm nothing is claimed
    wreg(4'h3, 32'h0);
    req(32'h8000_0010, 2'b00);
    req(32'hC000_1000, 2'b01);
    rreg(4'h3);
    step(0, 0, 0, 4'h0, 0, 0, 0);
    finish_run();
  end

endmodule